// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for 64 or 96 pins. Every feature of the pins is held in 32-bit words, one bit per pin and 32 pins per word. A feature therefore takes NUM_PINS/32 consecutive words. The only exception is the alternate-function selector, which packs 2 bits per pin and 16 pins per word. Software drives output levels with write-one strobes: one strobe word raises bits and another lowers them. Because of this, no read-modify-write of a data register is ever needed to change a single pin.

Pin inputs pass through a two-flop synchronizer before software can read them. The direction word drives the pin output-enables. The alternate-function codes are brought out raw for a pad mux outside this block. The three edge-related feature groups keep their slots in the address map, but a companion block owns them. This block reads them as zero and ignores writes to them.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The map has NW = NUM_PINS/32 words per feature. Word w is at byte address w*4, and address bits [1:0] are ignored. The word for feature group g and bank b is at byte g*NW*4 + b*4, where group 0 is level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge status and 7 alternate function. Pin p sits in bank p/32 at bit p%32. Read data is registered and appears one clock after the address is presented.
- R2: A read of the level group returns pin_in delayed by a two-flop synchronizer. A pin change becomes readable after two clock edges.
- R3: Writes to the level group change no state and no output.
- R4: Direction bit 1 makes a pin an output (pin_oe high) and 0 makes it an input. A write replaces the whole word, and a read returns it.
- R5: Writing the set group drives pin_out high for every 1 bit of the data. Zero bits leave their pins unchanged.
- R6: Writing the clear group drives pin_out low for every 1 bit of the data. Zero bits leave their pins unchanged.
- R7: A read of either the set group or the clear group returns the current output latch word for that bank.
- R8: The alternate-function group holds 2*NW words, starting at byte 7*NW*4. Pin p uses word p/16, bits [(p%16)*2 +: 2], and appears on pin_alt[2p+1:2p]. Code 0 means plain GPIO. A write replaces the word, and a read returns it.
- R9: The rising-enable, falling-enable and edge-status groups, and every address at or above byte 9*NW*4, read as 0. Writes to them change no state and no output.
- R10: After reset, all pins are inputs, the output latch is 0, every alternate code is 0 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write enable, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Output latch value for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin (direction bit) |
| pin_alt | output | 2*NUM_PINS | Alternate-function code for each pin, 2 bits per pin |

## Verification
The alternate-function words are the hardest part of the map to reach. Their upper half lies beyond the nominal eight-group span, the bank index there counts in halves of a pin word, and the 15/16 pin boundary inside each pair of words is easy to get wrong. The bench therefore writes every alternate word with a distinct pattern and then checks the 2-bit field of every one of the 96 pins against arithmetic on the pin number. It also sweeps every address from the end of the map up to the top of the address space. The set and clear strobes are walked one pin at a time, so that each latch bit is shown to move alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int LANE_W     = 32;
    localparam int ALT_PER_WD = 16;

    // Feature group order; decode and software both depend on it.
    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STAT  = 3'd6,
        GRP_ALT   = 3'd7
    } grp_e;

    typedef struct packed {
        logic lvl;
        logic dir;
        logic set;
        logic clr;
        logic edg;
        logic alt;
    } sel_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o = sync_q.s2;

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NW     = 2,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int ALT_BASE = int'(GRP_ALT) * NW;
    localparam int MAP_END  = ALT_BASE + 2 * NW;

    int word_i;
    int grp_i;

    always_comb begin
        word_i = int'(addr_i[ADDR_W-1:2]);
        grp_i  = word_i / NW;
        sel_o  = '0;
        idx_o  = '0;
        if (word_i < ALT_BASE) begin
            idx_o = IDX_W'(word_i - grp_i * NW);
            case (grp_e'(grp_i[2:0]))
                GRP_LEVEL: sel_o.lvl = 1'b1;
                GRP_DIR:   sel_o.dir = 1'b1;
                GRP_SET:   sel_o.set = 1'b1;
                GRP_CLR:   sel_o.clr = 1'b1;
                default:   sel_o.edg = 1'b1;
            endcase
        end else if (word_i < MAP_END) begin
            sel_o.alt = 1'b1;
            idx_o     = IDX_W'(word_i - ALT_BASE);
        end
    end

    // R1: at most one feature group decoded per address
    always_comb begin
        p_one_group_r1: assert ($onehot0(sel_o));
    end

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int N     = 64,
    parameter int NW    = 2,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  sel_t             sel_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      wdata_i,
    output logic [N-1:0]     dir_o,
    output logic [N-1:0]     lat_o,
    output logic [2*N-1:0]   alt_o
);

    typedef struct packed {
        logic [N-1:0]   dir;
        logic [N-1:0]   lat;
        logic [2*N-1:0] alt;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int b = 0; b < NW; b++) begin
            if (we_i && idx_i == IDX_W'(b)) begin
                if (sel_i.dir) regs_d.dir[b*LANE_W +: LANE_W] = wdata_i;
                if (sel_i.set) regs_d.lat[b*LANE_W +: LANE_W] =
                    regs_q.lat[b*LANE_W +: LANE_W] | wdata_i;
                if (sel_i.clr) regs_d.lat[b*LANE_W +: LANE_W] =
                    regs_q.lat[b*LANE_W +: LANE_W] & ~wdata_i;
            end
        end
        for (int k = 0; k < 2 * NW; k++) begin
            if (we_i && sel_i.alt && idx_i == IDX_W'(k))
                regs_d.alt[k*LANE_W +: LANE_W] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dir_o = regs_q.dir;
    assign lat_o = regs_q.lat;
    assign alt_o = regs_q.alt;

    // R3, R9: writes outside the owned groups leave all state untouched
    p_no_side_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !(sel_i.dir || sel_i.set || sel_i.clr || sel_i.alt))
        |=> ($stable(regs_q.dir) && $stable(regs_q.lat) && $stable(regs_q.alt)));

    for (genvar b = 0; b < NW; b++) begin : g_bank_chk
        p_set_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && sel_i.set && idx_i == IDX_W'(b))
            |=> ((regs_q.lat[b*LANE_W +: LANE_W] & $past(wdata_i)) == $past(wdata_i)));
        p_clr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && sel_i.clr && idx_i == IDX_W'(b))
            |=> ((regs_q.lat[b*LANE_W +: LANE_W] & $past(wdata_i)) == 32'h0));
        p_zero_bits_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && (sel_i.set || sel_i.clr) && idx_i == IDX_W'(b))
            |=> ((regs_q.lat[b*LANE_W +: LANE_W] & ~$past(wdata_i)) ==
                 ($past(regs_q.lat[b*LANE_W +: LANE_W]) & ~$past(wdata_i))));
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pin_alt
);

    localparam int NW    = NUM_PINS / LANE_W;
    localparam int IDX_W = $clog2(2 * NW);

    sel_t             dec_sel;
    logic [IDX_W-1:0] dec_idx;
    logic [NUM_PINS-1:0] lvl_sync;
    logic [NUM_PINS-1:0] dir_w, lat_w;
    logic [2*NUM_PINS-1:0] alt_w;

    gpio_in_sync #(.N(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pin_in),
        .lvl_o (lvl_sync)
    );

    gpio_addr_decode #(.NW(NW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (dec_sel),
        .idx_o  (dec_idx)
    );

    gpio_out_regs #(.N(NUM_PINS), .NW(NW), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .sel_i   (dec_sel),
        .idx_i   (dec_idx),
        .wdata_i (bus_wdata),
        .dir_o   (dir_w),
        .lat_o   (lat_w),
        .alt_o   (alt_w)
    );

    typedef struct packed {
        logic [31:0] rd;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.rd = '0;
        for (int b = 0; b < NW; b++) begin
            if (dec_idx == IDX_W'(b)) begin
                if (dec_sel.lvl)                rd_d.rd = lvl_sync[b*LANE_W +: LANE_W];
                if (dec_sel.dir)                rd_d.rd = dir_w[b*LANE_W +: LANE_W];
                if (dec_sel.set || dec_sel.clr) rd_d.rd = lat_w[b*LANE_W +: LANE_W];
            end
        end
        for (int k = 0; k < 2 * NW; k++) begin
            if (dec_sel.alt && dec_idx == IDX_W'(k))
                rd_d.rd = alt_w[k*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rd;
    assign pin_out   = lat_w;
    assign pin_oe    = dir_w;
    assign pin_alt   = alt_w;

    // R9: addresses owned elsewhere or unmapped return zero next cycle
    p_dead_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_sel.edg || !(|dec_sel)) |=> (bus_rdata == 32'h0));

    // R7: set and clear words read back the output latch of the same bank
    p_strobe_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_sel.set || dec_sel.clr) && !bus_we && dec_idx == '0)
        |=> (bus_rdata == pin_out[31:0]));

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

    localparam int NP = 96;
    localparam int AW = 8;
    localparam int NW = NP / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out, pin_oe;
    logic [2*NP-1:0] pin_alt;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [NP-1:0]   m_dir = '0;
    logic [NP-1:0]   m_lat = '0;
    logic [2*NP-1:0] m_alt = '0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt)
    );

    function automatic int addr_of(int g, int b);
        return g * NW * 4 + b * 4;
    endfunction

    task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic outs_ok(string req);
        chk(req, 256'(pin_out), 256'(m_lat));
        chk(req, 256'(pin_oe),  256'(m_dir));
        chk(req, 256'(pin_alt), 256'(m_alt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        outs_ok("R10");
        chk("R10", 256'(bus_rdata), 256'(0));
        rd(addr_of(1, 0), v);
        chk("R10 dir", 256'(v), 256'(0));

        // R5: walk a single set strobe over every pin
        for (int p = 0; p < NP; p++) begin
            wr(addr_of(2, p / 32), 32'h1 << (p % 32));
            m_lat[p] = 1'b1;
            chk("R5", 256'(pin_out), 256'(m_lat));
        end
        // R5: all-zero set data changes nothing
        wr(addr_of(2, 1), 32'h0);
        chk("R5 zero", 256'(pin_out), 256'(m_lat));
        // R6: clear odd pins one at a time
        for (int p = 1; p < NP; p += 2) begin
            wr(addr_of(3, p / 32), 32'h1 << (p % 32));
            m_lat[p] = 1'b0;
            chk("R6", 256'(pin_out), 256'(m_lat));
        end
        // R7: both strobe words read the latch
        for (int b = 0; b < NW; b++) begin
            rd(addr_of(2, b), v);
            chk("R7 set", 256'(v), 256'(m_lat[b*32 +: 32]));
            rd(addr_of(3, b), v);
            chk("R7 clr", 256'(v), 256'(m_lat[b*32 +: 32]));
        end

        // R4: direction words with distinct patterns
        for (int b = 0; b < NW; b++) begin
            v = 32'h9E3779B9 * (b + 1);
            wr(addr_of(1, b), v);
            m_dir[b*32 +: 32] = v;
            chk("R4 oe", 256'(pin_oe), 256'(m_dir));
        end
        for (int b = 0; b < NW; b++) begin
            rd(addr_of(1, b), v);
            chk("R4 read", 256'(v), 256'(m_dir[b*32 +: 32]));
        end
        // R1: low address bits ignored
        wr(addr_of(1, 1) + 3, 32'h0F0F_1234);
        m_dir[63:32] = 32'h0F0F_1234;
        rd(addr_of(1, 1) + 1, v);
        chk("R1 lanes", 256'(v), 256'(32'h0F0F_1234));
        chk("R1 oe", 256'(pin_oe), 256'(m_dir));

        // R8: alternate-function words, per-pin field check
        for (int k = 0; k < 2 * NW; k++) begin
            v = 32'hC3A5_0F96 ^ (32'h0101_0101 * k);
            wr(addr_of(7, 0) + k * 4, v);
            for (int p = k * 16; p < k * 16 + 16; p++)
                m_alt[2*p +: 2] = 2'((v >> ((p % 16) * 2)) & 32'h3);
        end
        for (int p = 0; p < NP; p++)
            chk("R8 pin", 256'(pin_alt[2*p +: 2]), 256'(m_alt[2*p +: 2]));
        for (int k = 0; k < 2 * NW; k++) begin
            rd(addr_of(7, 0) + k * 4, v);
            chk("R8 read", 256'(v), 256'(m_alt[k*32 +: 32]));
        end

        // R2: walking one through the synchronizer
        for (int p = 0; p < NP; p++) begin
            @(negedge clk);
            pin_in = NP'(1) << p;
            repeat (2) @(negedge clk);
            rd(addr_of(0, p / 32), v);
            chk("R2", 256'(v), 256'(32'h1 << (p % 32)));
        end

        // R3: level group is read-only
        pin_in = {3{32'hA5C3_3C5A}};
        repeat (3) @(negedge clk);
        for (int b = 0; b < NW; b++) begin
            wr(addr_of(0, b), 32'hFFFF_FFFF);
            outs_ok("R3");
            rd(addr_of(0, b), v);
            chk("R3 level", 256'(v), 256'(32'hA5C3_3C5A));
        end

        // R9: edge groups owned elsewhere
        for (int g = 4; g < 7; g++) begin
            for (int b = 0; b < NW; b++) begin
                wr(addr_of(g, b), 32'hFFFF_FFFF);
                outs_ok("R9 edge");
                rd(addr_of(g, b), v);
                chk("R9 edge read", 256'(v), 256'(0));
            end
        end
        // R9: everything past the map reads zero and ignores writes
        for (int a = 9 * NW * 4; a < (1 << AW); a += 4) begin
            rd(addr_of(1, 0), v);
            wr(a, 32'hFFFF_FFFF);
            outs_ok("R9 beyond");
            rd(a, v);
            chk("R9 beyond read", 256'(v), 256'(0));
        end

        // R6: clear everything
        for (int b = 0; b < NW; b++) wr(addr_of(3, b), 32'hFFFF_FFFF);
        m_lat = '0;
        chk("R6 all", 256'(pin_out), 256'(0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule